// File: doc/BRIEF.md
# Store Queue with Read Forwarding

This block sits between a write-through cache and main memory. Because every store is sent toward memory as soon as the cache takes it, each store first lands in a small first-in, first-out queue of address and data pairs. The queue passes its oldest entry to memory through a valid/ready handshake. When the queue is full, it pushes back on the cache side.

Loads from the processor can refer to an address whose newest value is still waiting in the queue. For that reason every read address is compared against all pending entries at the same time. If an entry matches, the block reports a hit and returns the data of the youngest matching entry. Hit and data are combinational from the read address and the queue state, so the cache can pick the forwarded value in the same cycle.

Top module: `wrbuf_top`

## Requirements
- R1: After reset the queue is empty: `enq_ready` is 1, `mem_valid` is 0 and `rd_hit` is 0 for any `rd_addr`.
- R2: A store is accepted on a rising edge where `enq_valid` and `enq_ready` are both 1. It is appended behind all earlier stores and is pending from the next cycle.
- R3: With `DEPTH` (default 4) entries pending, `enq_ready` is 0. A store offered while `enq_ready` is 0 is not taken and leaves the pending contents unchanged.
- R4: `mem_valid` is 1 exactly when at least one entry is pending. `mem_addr` and `mem_data` then show the oldest pending entry.
- R5: Entries leave in the order they arrived, one for each rising edge with `mem_valid` and `mem_ready` both 1. While `mem_ready` is 0, the offered entry holds steady.
- R6: An accepted store and a completed drain on the same edge leave the number of pending entries unchanged.
- R7: `rd_hit` is 1 in the same cycle when some pending entry has an address equal to `rd_addr`. `rd_data` then carries that entry's data.
- R8: When several pending entries match `rd_addr`, `rd_data` is the data of the most recently accepted one.
- R9: `rd_hit` is 0 when no pending entry matches. This includes addresses whose entries have already drained.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Cache offers a store |
| enq_ready | output | 1 | Queue can take a store this cycle |
| enq_addr | input | AW | Store address |
| enq_data | input | DW | Store data |
| mem_valid | output | 1 | Oldest entry is offered to memory |
| mem_ready | input | 1 | Memory takes the offered entry |
| mem_addr | output | AW | Address of the oldest entry |
| mem_data | output | DW | Data of the oldest entry |
| rd_addr | input | AW | Read reference address to search |
| rd_hit | output | 1 | A pending entry matches `rd_addr` |
| rd_data | output | DW | Data of the youngest matching entry |

## Verification
All outputs are combinational from the registered queue state and `rd_addr`. A store or drain that completes on a rising edge therefore shows up in `enq_ready`, `mem_*` and `rd_*` during the very next cycle, one register away. A lookup answer is due in the same cycle as its address. The bench drives inputs on the falling edge and compares every output against its queue model 1 ns later, before the next rising edge. It updates the model only after that edge, so each comparison sees exactly the state the design holds.

// File: rtl/wrbuf_pkg.sv
package wrbuf_pkg;

  // position 'off' steps ahead of 'base' on a ring of 'depth' slots
  function automatic int ring_add(input int base, input int off, input int depth);
    return (base + off) % depth;
  endfunction

  // next slot index with wrap
  function automatic int ring_next(input int ptr, input int depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/wrbuf_ctrl.sv
module wrbuf_ctrl #(
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          push,
  output logic          pop,
  output logic [PW-1:0] head,
  output logic [PW-1:0] tail,
  output logic [CW-1:0] occ,
  output logic          full,
  output logic          empty
);
  assign full  = (occ == CW'(DEPTH));
  assign empty = (occ == '0);
  assign push  = push_req && !full;
  assign pop   = pop_req && !empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      occ  <= '0;
    end else begin
      if (push) tail <= PW'(wrbuf_pkg::ring_next(int'(tail), DEPTH));
      if (pop)  head <= PW'(wrbuf_pkg::ring_next(int'(head), DEPTH));
      case ({push, pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end
endmodule

// File: rtl/wrbuf_store.sv
module wrbuf_store #(
  parameter int DEPTH = 4,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push,
  input  logic                      pop,
  input  logic [PW-1:0]             head,
  input  logic [PW-1:0]             tail,
  input  logic [AW-1:0]             wr_addr,
  input  logic [DW-1:0]             wr_data,
  output logic [DEPTH-1:0][AW-1:0]  slot_addr,
  output logic [DEPTH-1:0][DW-1:0]  slot_data,
  output logic [DEPTH-1:0]          slot_live
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_live[i] <= 1'b0;
        slot_addr[i] <= '0;
        slot_data[i] <= '0;
      end else begin
        if (pop && head == PW'(i)) slot_live[i] <= 1'b0;
        if (push && tail == PW'(i)) begin
          slot_live[i] <= 1'b1;
          slot_addr[i] <= wr_addr;
          slot_data[i] <= wr_data;
        end
      end
    end
  end
endmodule

// File: rtl/wrbuf_match.sv
module wrbuf_match #(
  parameter int DEPTH = 4,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0][AW-1:0] slot_addr,
  input  logic [DEPTH-1:0][DW-1:0] slot_data,
  input  logic [DEPTH-1:0]         slot_live,
  input  logic [PW-1:0]            head,
  input  logic [AW-1:0]            rd_addr,
  output logic                     hit,
  output logic [DW-1:0]            data
);
  logic [DEPTH-1:0] mvec;
  logic [PW-1:0]    sel;
  logic [PW-1:0]    slot;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign mvec[i] = slot_live[i] && (slot_addr[i] == rd_addr);
  end

  // walk oldest to youngest; the last match found is the youngest
  always_comb begin
    hit  = 1'b0;
    sel  = '0;
    slot = '0;
    for (int k = 0; k < DEPTH; k++) begin
      slot = PW'(wrbuf_pkg::ring_add(int'(head), k, DEPTH));
      if (mvec[slot]) begin
        hit = 1'b1;
        sel = slot;
      end
    end
    data = hit ? slot_data[sel] : '0;
  end
endmodule

// File: rtl/wrbuf_top.sv
module wrbuf_top #(
  parameter int DEPTH = 4,
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enq_valid,
  output logic          enq_ready,
  input  logic [AW-1:0] enq_addr,
  input  logic [DW-1:0] enq_data,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_hit,
  output logic [DW-1:0] rd_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic                     push, pop, full, empty;
  logic [PW-1:0]            head, tail;
  logic [CW-1:0]            occ;
  logic [DEPTH-1:0][AW-1:0] slot_addr;
  logic [DEPTH-1:0][DW-1:0] slot_data;
  logic [DEPTH-1:0]         slot_live;

  wrbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .push_req(enq_valid), .pop_req(mem_ready),
    .push(push), .pop(pop), .head(head), .tail(tail), .occ(occ),
    .full(full), .empty(empty)
  );

  wrbuf_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .head(head), .tail(tail),
    .wr_addr(enq_addr), .wr_data(enq_data),
    .slot_addr(slot_addr), .slot_data(slot_data), .slot_live(slot_live)
  );

  wrbuf_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_match (
    .slot_addr(slot_addr), .slot_data(slot_data), .slot_live(slot_live),
    .head(head), .rd_addr(rd_addr), .hit(rd_hit), .data(rd_data)
  );

  assign enq_ready = !full;
  assign mem_valid = !empty;
  assign mem_addr  = slot_addr[head];
  assign mem_data  = slot_data[head];
endmodule

// File: rtl/wrbuf_chk.sv
module wrbuf_chk #(
  parameter int DEPTH = 4,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enq_ready,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_data,
  input logic          rd_hit,
  input logic          push,
  input logic          pop,
  input logic [CW-1:0] occ
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) occ <= CW'(DEPTH)); // R3
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n) (occ == CW'(DEPTH)) |-> !enq_ready); // R3
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n) (push && !pop) |=> (occ == $past(occ) + 1'b1)); // R2
  AST_SWAP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) (push && pop) |=> (occ == $past(occ))); // R6
  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data))); // R5
  AST_OFFER_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n) mem_valid |-> (occ != '0)); // R4
  AST_EMPTY_MISS: assert property (@(posedge clk) disable iff (!rst_n) (occ == '0) |-> !rd_hit); // R9
endmodule

bind wrbuf_top wrbuf_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enq_ready(enq_ready), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
  .rd_hit(rd_hit), .push(push), .pop(pop), .occ(occ)
);

// File: tb/test_wrbuf_top.sv
module test_wrbuf_top;
  localparam int DEPTH = 4;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enq_valid = 1'b0, mem_ready = 1'b0;
  logic [AW-1:0] enq_addr = '0, rd_addr = '0;
  logic [DW-1:0] enq_data = '0;
  logic          enq_ready, mem_valid, rd_hit;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data, rd_data;

  int checks = 0;
  int errors = 0;
  logic [AW-1:0] qa[$];
  logic [DW-1:0] qd[$];

  always #2 clk = ~clk;

  wrbuf_top #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_wrbuf_top (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_ready(enq_ready),
    .enq_addr(enq_addr), .enq_data(enq_data), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .rd_addr(rd_addr), .rd_hit(rd_hit), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, compare, then advance the model after the rising edge
  task automatic cyc(input bit ev, input logic [AW-1:0] ea, input logic [DW-1:0] ed,
                     input bit mr, input logic [AW-1:0] ra, input string tag);
    bit er, mv, eh, pe, pp;
    logic [DW-1:0] edat;
    @(negedge clk);
    enq_valid = ev; enq_addr = ea; enq_data = ed; mem_ready = mr; rd_addr = ra;
    #1;
    er = (qa.size() < DEPTH);
    mv = (qa.size() > 0);
    eh = 1'b0; edat = '0;
    foreach (qa[i]) if (qa[i] == ra) begin eh = 1'b1; edat = qd[i]; end
    chk(enq_ready == er, {tag, " R3 enq_ready"}, 64'(enq_ready), 64'(er));
    chk(mem_valid == mv, {tag, " R4 mem_valid"}, 64'(mem_valid), 64'(mv));
    if (mv) begin
      chk(mem_addr == qa[0], {tag, " R5 mem_addr"}, 64'(mem_addr), 64'(qa[0]));
      chk(mem_data == qd[0], {tag, " R5 mem_data"}, 64'(mem_data), 64'(qd[0]));
    end
    chk(rd_hit == eh, {tag, " R7 rd_hit"}, 64'(rd_hit), 64'(eh));
    if (eh) chk(rd_data == edat, {tag, " R8 rd_data"}, 64'(rd_data), 64'(edat));
    @(posedge clk);
    pe = ev && er;
    pp = mr && mv;
    if (pp) begin void'(qa.pop_front()); void'(qd.pop_front()); end
    if (pe) begin qa.push_back(ea); qd.push_back(ed); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state
    rd_addr = 32'h40;
    #1;
    chk(enq_ready == 1'b1, "R1 enq_ready after reset", 64'(enq_ready), 64'd1);
    chk(mem_valid == 1'b0, "R1 mem_valid after reset", 64'(mem_valid), 64'd0);
    chk(rd_hit == 1'b0, "R1 rd_hit after reset", 64'(rd_hit), 64'd0);

    // R2: fill with memory stalled, duplicates at 0x40
    cyc(1, 32'h40, 32'hA0, 0, 32'h40, "R2 fill0");
    cyc(1, 32'h44, 32'hA1, 0, 32'h40, "R2 fill1");
    cyc(1, 32'h40, 32'hA2, 0, 32'h40, "R8 fill2");
    cyc(1, 32'h48, 32'hA3, 0, 32'h40, "R8 fill3");
    // R3: offers while full are dropped
    cyc(1, 32'h40, 32'hEE, 0, 32'h40, "R3 full0");
    cyc(1, 32'h4C, 32'hEF, 0, 32'h4C, "R3 full1");
    chk(enq_ready == 1'b0, "R3 enq_ready low while full", 64'(enq_ready), 64'd0);
    // R9: miss on unknown address
    cyc(0, 0, 0, 0, 32'h80, "R9 miss");
    chk(rd_hit == 1'b0, "R9 rd_hit for absent address", 64'(rd_hit), 64'd0);
    // R6: push and drain together while full is blocked; do it with one slot free
    cyc(0, 0, 0, 1, 32'h40, "R5 drain0");
    cyc(1, 32'h50, 32'hB0, 1, 32'h40, "R6 swap");
    chk(enq_ready == 1'b1, "R6 occupancy unchanged, one slot free", 64'(enq_ready), 64'd1);
    // R5/R9: drain the rest in order; drained addresses stop hitting
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 32'h44, "R5 drain");
    cyc(0, 0, 0, 0, 32'h44, "R9 drained");
    chk(rd_hit == 1'b0, "R9 drained address misses", 64'(rd_hit), 64'd0);
    chk(mem_valid == 1'b0, "R4 empty after drain", 64'(mem_valid), 64'd0);

    // mixed traffic over a small address set so matches repeat
    for (int n = 0; n < 400; n++) begin
      cyc(($urandom % 10) < 6, 32'h100 + 4 * ($urandom % 4), $urandom,
          ($urandom % 2) == 1, 32'h100 + 4 * ($urandom % 5), "mix");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule